// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detection

This block is one eight-pin general-purpose I/O port behind a small word-addressed register interface. Software picks a drive mode for each pin, drives a per-pin output latch through full writes or through atomic set and clear writes, and can protect any latch bit against every write path with a per-pin mask. The pad side receives an output-enable and an output value per pin. Input values are sampled into an input register, either straight from the pad or through a per-pin three-flop synchronizer.

Each pin can raise a sticky interrupt flag. A pin is either edge-type or level-type, with a polarity bit choosing rising/high or falling/low. An any-edge bit, which acts only on edge-type pins, makes both directions count whatever the polarity says. Flags set only on enabled pins, are cleared by writing ones to a clear address, and are ORed into one interrupt line.

The interface is a single-cycle write strobe with a 4-bit word address and a 32-bit data bus. Read data is combinational from the address. The word indices are 0 mode, 1 mask, 2 output, 3 input, 4 enable, 5 flags, 7 flag clear, 8 type, 9 polarity, 10 any-edge, 11 synchronizer, 12 set and 13 clear.

Top module: `gpio_port`

## Requirements
- R1: After reset every register is 0, every address reads 0 (the pad input is held low), `pad_oe` is 0 and `irq` is 0.
- R2: Pin n takes its mode from bits [2n+1:2n] of word 0. Code 1 (push-pull) drives `pad_oe`=1 and `pad_out`=latch. Code 2 (open-drain) drives `pad_oe` only while the latch is 0, with `pad_out`=0. Codes 0 (analog) and 3 (high-impedance input) drive `pad_oe`=0 and `pad_out`=0.
- R3: A write to word 2 loads the unmasked latch bits from `wdata[7:0]`. The latch reads back at word 2 and reaches the pads on the cycle after the write edge.
- R4: A write to word 12 sets each latch bit whose data bit is 1, and a write to word 13 clears each such bit. Bits written as 0 keep their value.
- R5: While bit n of the mask (word 1) is 1, writes to words 2, 12 and 13 leave latch bit n unchanged.
- R6: Word 3 returns the sampled input. With synchronizer bit n (word 11) at 0, a pad change is readable after 1 clock edge. With the bit at 1, it is readable after 4 edges and not after 3.
- R7: An edge-type pin (type bit 0 in word 8) flags on a rising edge when its polarity bit (word 9) is 1 and on a falling edge when the bit is 0.
- R8: An edge-type pin whose any-edge bit (word 10) is 1 flags on both edges, whatever its polarity bit.
- R9: A level-type pin (type bit 1) flags while the input equals its polarity bit. A clear does not remove the flag while that level persists.
- R10: A flag bit sets only while the pin's enable bit (word 4) is 1. Disabled pins never flag.
- R11: Writing word 7 clears each flag whose data bit is 1. Bits written 0 are kept. A new detection in the same cycle wins over the clear. Flags read at word 5, and writes to word 5 are ignored.
- R12: `irq` is 1 exactly when some flag bit is 1. Words 7, 12 and 13 and unused words read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe, one write per cycle |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output-enable per pin |
| pad_out | output | 8 | Pad output value per pin |
| irq | output | 1 | OR of all interrupt flags |

## Verification
Register writes, pad drive and readback take effect on the edge that accepts the write, so the bench performs each write between two falling edges and checks on the following falling edge. An input change is due in the input register 1 edge after it is applied, or 4 edges after it when the synchronizer is on; the bench samples at exactly 3 and 4 edges to bound the synchronized path. A flag follows the input register by one more edge, and the interrupt sweeps hold each pad pattern for six edges so that both input paths settle before the flags are compared. The expected flags come from an arithmetic model of edge, level, polarity and enable over several configurations, run once with the synchronizer off and once with it on.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_ADDR_W = 4;
    typedef logic [REG_ADDR_W-1:0] reg_idx_t;

    localparam reg_idx_t IDX_MODE  = 4'd0;
    localparam reg_idx_t IDX_MASK  = 4'd1;
    localparam reg_idx_t IDX_OUT   = 4'd2;
    localparam reg_idx_t IDX_IN    = 4'd3;
    localparam reg_idx_t IDX_IE    = 4'd4;
    localparam reg_idx_t IDX_FLAG  = 4'd5;
    localparam reg_idx_t IDX_ICLR  = 4'd7;
    localparam reg_idx_t IDX_TYPE  = 4'd8;
    localparam reg_idx_t IDX_POL   = 4'd9;
    localparam reg_idx_t IDX_ANY   = 4'd10;
    localparam reg_idx_t IDX_SYNC  = 4'd11;
    localparam reg_idx_t IDX_SET   = 4'd12;
    localparam reg_idx_t IDX_CLR   = 4'd13;

    typedef enum logic [1:0] {
        PM_ANALOG    = 2'd0,
        PM_PUSHPULL  = 2'd1,
        PM_OPENDRAIN = 2'd2,
        PM_HIZ       = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_in,
    input  logic [N_PINS-1:0] sync_en,
    output logic [N_PINS-1:0] in_q
);

    logic [N_PINS-1:0] sel_bit;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pad_in[p]};
            end
        end

        assign sel_bit[p] = sync_en[p] ? chain_q[STAGES-1] : pad_in[p];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= sel_bit;
        end
    end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] in_q,
    input  logic [N_PINS-1:0] ie,
    input  logic [N_PINS-1:0] lvl_type,
    input  logic [N_PINS-1:0] pol,
    input  logic [N_PINS-1:0] any_edge,
    input  logic              clr_we,
    input  logic [N_PINS-1:0] clr_bits,
    output logic [N_PINS-1:0] flag_q,
    output logic              irq
);

    logic [N_PINS-1:0] prev_q;
    logic [N_PINS-1:0] rise;
    logic [N_PINS-1:0] fall;
    logic [N_PINS-1:0] edge_hit;
    logic [N_PINS-1:0] level_hit;
    logic [N_PINS-1:0] hit;
    logic [N_PINS-1:0] clr_mask;

    always_comb begin
        rise      = in_q & ~prev_q;
        fall      = ~in_q & prev_q;
        edge_hit  = (any_edge & (rise | fall))
                  | (~any_edge & pol & rise)
                  | (~any_edge & ~pol & fall);
        level_hit = ~(in_q ^ pol);
        hit       = ie & ((lvl_type & level_hit) | (~lvl_type & edge_hit));
        clr_mask  = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= in_q;
            flag_q <= (flag_q & ~clr_mask) | hit;
        end
    end

    assign irq = |flag_q;

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic [2*N_PINS-1:0] mode,
    input  logic [N_PINS-1:0]   latch,
    output logic [N_PINS-1:0]   pad_oe,
    output logic [N_PINS-1:0]   pad_out
);

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        pin_mode_e pm;
        logic      oe_b;
        logic      d_b;

        assign pm = pin_mode_e'(mode[2*p +: 2]);

        always_comb begin
            unique case (pm)
                PM_PUSHPULL: begin
                    oe_b = 1'b1;
                    d_b  = latch[p];
                end
                PM_OPENDRAIN: begin
                    oe_b = ~latch[p];
                    d_b  = 1'b0;
                end
                default: begin
                    oe_b = 1'b0;
                    d_b  = 1'b0;
                end
            endcase
        end

        assign pad_oe[p]  = oe_b;
        assign pad_out[p] = d_b;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [N_PINS-1:0]     pad_in,
    output logic [N_PINS-1:0]     pad_oe,
    output logic [N_PINS-1:0]     pad_out,
    output logic                  irq
);

    localparam int MODE_W = 2 * N_PINS;

    logic [MODE_W-1:0] mode_q;
    logic [N_PINS-1:0] mask_q;
    logic [N_PINS-1:0] out_q;
    logic [N_PINS-1:0] ie_q;
    logic [N_PINS-1:0] typ_q;
    logic [N_PINS-1:0] pol_q;
    logic [N_PINS-1:0] any_q;
    logic [N_PINS-1:0] sync_q;
    logic [N_PINS-1:0] in_q;
    logic [N_PINS-1:0] flag_q;
    logic [N_PINS-1:0] wpin;
    logic [N_PINS-1:0] wfree;
    logic              clr_we;
    logic              unused_wdata_hi;

    assign wpin            = wdata[N_PINS-1:0];
    assign wfree           = wpin & ~mask_q;
    assign clr_we          = we && (addr == IDX_ICLR);
    assign unused_wdata_hi = ^wdata[DATA_W-1:MODE_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
            out_q  <= '0;
            ie_q   <= '0;
            typ_q  <= '0;
            pol_q  <= '0;
            any_q  <= '0;
            sync_q <= '0;
        end else if (we) begin
            case (addr)
                IDX_MODE: mode_q <= wdata[MODE_W-1:0];
                IDX_MASK: mask_q <= wpin;
                IDX_OUT:  out_q  <= (out_q & mask_q) | wfree;
                IDX_SET:  out_q  <= out_q | wfree;
                IDX_CLR:  out_q  <= out_q & ~wfree;
                IDX_IE:   ie_q   <= wpin;
                IDX_TYPE: typ_q  <= wpin;
                IDX_POL:  pol_q  <= wpin;
                IDX_ANY:  any_q  <= wpin;
                IDX_SYNC: sync_q <= wpin;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            IDX_MODE: rdata = DATA_W'(mode_q);
            IDX_MASK: rdata = DATA_W'(mask_q);
            IDX_OUT:  rdata = DATA_W'(out_q);
            IDX_IN:   rdata = DATA_W'(in_q);
            IDX_IE:   rdata = DATA_W'(ie_q);
            IDX_FLAG: rdata = DATA_W'(flag_q);
            IDX_TYPE: rdata = DATA_W'(typ_q);
            IDX_POL:  rdata = DATA_W'(pol_q);
            IDX_ANY:  rdata = DATA_W'(any_q);
            IDX_SYNC: rdata = DATA_W'(sync_q);
            default:  rdata = '0;
        endcase
    end

    gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .sync_en (sync_q),
        .in_q    (in_q)
    );

    gpio_irq_unit #(.N_PINS(N_PINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_q     (in_q),
        .ie       (ie_q),
        .lvl_type (typ_q),
        .pol      (pol_q),
        .any_edge (any_q),
        .clr_we   (clr_we),
        .clr_bits (wpin),
        .flag_q   (flag_q),
        .irq      (irq)
    );

    gpio_pad_drive #(.N_PINS(N_PINS)) u_pad (
        .mode    (mode_q),
        .latch   (out_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

endmodule

// File: rtl/gpio_port_props.sv
module gpio_port_props
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  we,
    input logic [REG_ADDR_W-1:0] addr,
    input logic [DATA_W-1:0]     wdata,
    input logic [DATA_W-1:0]     rdata,
    input logic [N_PINS-1:0]     pad_oe,
    input logic [N_PINS-1:0]     pad_out,
    input logic                  irq,
    input logic [2*N_PINS-1:0]   mode_q,
    input logic [N_PINS-1:0]     mask_q,
    input logic [N_PINS-1:0]     out_q,
    input logic [N_PINS-1:0]     ie_q,
    input logic [N_PINS-1:0]     flag_q
);

    logic [N_PINS-1:0] pp_vec;
    logic [N_PINS-1:0] nodrive_vec;

    always_comb begin
        for (int p = 0; p < N_PINS; p++) begin
            pp_vec[p]      = (mode_q[2*p +: 2] == 2'd1);
            nodrive_vec[p] = (mode_q[2*p +: 2] == 2'd0) || (mode_q[2*p +: 2] == 2'd3);
        end
    end

    // R2: only push-pull pins may present a high output value
    a_r2_high_only_pushpull: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((pad_out & ~pp_vec) == '0));

    // R2: analog and input pins never enable their driver
    a_r2_inputs_float: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((pad_oe & nodrive_vec) == '0));

    // R5: masked latch bits never move
    a_r5_mask_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));

    // R4: set write raises every unmasked selected bit
    a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == IDX_SET) |=>
        ((out_q & $past(wdata[N_PINS-1:0] & ~mask_q)) == $past(wdata[N_PINS-1:0] & ~mask_q)));

    // R4: clear write lowers every unmasked selected bit
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == IDX_CLR) |=>
        ((out_q & $past(wdata[N_PINS-1:0] & ~mask_q)) == '0));

    // R10: a flag bit never rises on a disabled pin
    a_r10_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(ie_q)) == '0));

    // R11: the interrupt line only drops after a flag-clear write
    a_r11_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(we && addr == IDX_ICLR));

    // R12: strobe-only addresses read back as zero
    a_r12_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == IDX_SET || addr == IDX_CLR || addr == IDX_ICLR) |-> (rdata == '0));

endmodule

bind gpio_port gpio_port_props #(.N_PINS(N_PINS), .DATA_W(DATA_W)) u_props (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .irq     (irq),
    .mode_q  (mode_q),
    .mask_q  (mask_q),
    .out_q   (out_q),
    .ie_q    (ie_q),
    .flag_q  (flag_q)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
    import gpio_port_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [7:0]  pad_in;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(reg_idx_t a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(reg_idx_t a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] fill_mode(logic [1:0] m);
        logic [15:0] r;
        for (int p = 0; p < N; p++) r[2*p +: 2] = m;
        return r;
    endfunction

    task automatic exp_drive(logic [15:0] md, logic [7:0] lat,
                             output logic [7:0] oe, output logic [7:0] dq);
        for (int p = 0; p < N; p++) begin
            case (md[2*p +: 2])
                2'd1:    begin oe[p] = 1'b1;     dq[p] = lat[p]; end
                2'd2:    begin oe[p] = ~lat[p];  dq[p] = 1'b0;   end
                default: begin oe[p] = 1'b0;     dq[p] = 1'b0;   end
            endcase
        end
    endtask

    function automatic logic [7:0] model_hit(logic [7:0] typ, logic [7:0] pol, logic [7:0] anyb,
                                             logic [7:0] ie, logic [7:0] oldv, logic [7:0] newv,
                                             bit with_edge);
        logic [7:0] rise, fall, eh, lh;
        rise = newv & ~oldv;
        fall = ~newv & oldv;
        eh = (anyb & (rise | fall)) | (~anyb & pol & rise) | (~anyb & ~pol & fall);
        if (!with_edge) eh = '0;
        lh = (newv & pol) | (~newv & ~pol);
        return ie & ((typ & lh) | (~typ & eh));
    endfunction

    task automatic irq_sweep(logic [7:0] typ, logic [7:0] pol, logic [7:0] anyb,
                             logic [7:0] ie, logic [7:0] syn);
        logic [31:0] v;
        logic [7:0]  expf, cur;
        logic [7:0]  seq [5];
        seq = '{8'h3C, 8'hFF, 8'h0F, 8'h00, 8'hA5};
        wr(IDX_IE, 0);
        wr(IDX_SYNC, {24'h0, syn});
        @(negedge clk); pad_in = 8'h00;
        wait_cyc(6);
        wr(IDX_TYPE, {24'h0, typ});
        wr(IDX_POL,  {24'h0, pol});
        wr(IDX_ANY,  {24'h0, anyb});
        wr(IDX_ICLR, 32'hFF);
        rd(IDX_FLAG, v); chk("R10 flags empty while disabled", v, 0);
        wr(IDX_IE, {24'h0, ie});
        cur  = 8'h00;
        expf = model_hit(typ, pol, anyb, ie, cur, cur, 1'b0);
        wait_cyc(2);
        rd(IDX_FLAG, v); chk("R9 level flags at start", v, {24'h0, expf});
        foreach (seq[i]) begin
            @(negedge clk); pad_in = seq[i];
            wait_cyc(6);
            expf = expf | model_hit(typ, pol, anyb, ie, cur, seq[i], 1'b1);
            cur = seq[i];
            rd(IDX_FLAG, v); chk("R7 R8 R9 R10 flags after pad step", v, {24'h0, expf});
            chk("R12 irq is OR of flags", {31'h0, irq}, {31'h0, |expf});
        end
        wr(IDX_ICLR, 32'h0F);
        expf = (expf & 8'hF0) | model_hit(typ, pol, anyb, ie, cur, cur, 1'b0);
        rd(IDX_FLAG, v); chk("R11 partial clear, level rearms", v, {24'h0, expf});
        wr(IDX_ICLR, 32'h00);
        rd(IDX_FLAG, v); chk("R11 zero clear keeps flags", v, {24'h0, expf});
        wr(IDX_FLAG, 32'hFF);
        rd(IDX_FLAG, v); chk("R11 flag word write ignored", v, {24'h0, expf});
        wr(IDX_ICLR, 32'hFF);
        expf = model_hit(typ, pol, anyb, ie, cur, cur, 1'b0);
        rd(IDX_FLAG, v); chk("R9 R11 full clear", v, {24'h0, expf});
        chk("R12 irq after clear", {31'h0, irq}, {31'h0, |expf});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  eo, ed, model;
        logic [15:0] md;
        logic [7:0]  masks [5];
        logic [7:0]  lats [3];
        masks = '{8'h00, 8'hFF, 8'h0F, 8'hA5, 8'h3C};
        lats  = '{8'h5A, 8'hFF, 8'h00};

        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pad_in = '0;
        wait_cyc(3);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(reg_idx_t'(a), v);
            chk("R1 reset readback", v, 0);
        end
        chk("R1 reset pad_oe", {24'h0, pad_oe}, 0);
        chk("R1 reset irq", {31'h0, irq}, 0);

        // R2: uniform modes and a mixed mode word, several latch patterns
        for (int m = 0; m < 5; m++) begin
            md = (m < 4) ? fill_mode(m[1:0]) : 16'hE4E4;
            wr(IDX_MODE, {16'h0, md});
            rd(IDX_MODE, v); chk("R2 mode readback", v, {16'h0, md});
            foreach (lats[i]) begin
                wr(IDX_OUT, {24'h0, lats[i]});
                exp_drive(md, lats[i], eo, ed);
                chk("R2 pad_oe by mode", {24'h0, pad_oe}, {24'h0, eo});
                chk("R2 pad_out by mode", {24'h0, pad_out}, {24'h0, ed});
            end
        end

        // R3 R4 R5: latch writes under a set of masks, push-pull drive
        wr(IDX_MODE, {16'h0, fill_mode(2'd1)});
        foreach (masks[i]) begin
            wr(IDX_MASK, 0);
            wr(IDX_OUT, 32'h96);
            model = 8'h96;
            wr(IDX_MASK, {24'h0, masks[i]});
            wr(IDX_OUT, 32'h5A);
            model = (model & masks[i]) | (8'h5A & ~masks[i]);
            rd(IDX_OUT, v); chk("R3 R5 output write under mask", v, {24'h0, model});
            chk("R3 pad_out follows latch", {24'h0, pad_out}, {24'h0, model});
            wr(IDX_SET, 32'hF0);
            model = model | (8'hF0 & ~masks[i]);
            rd(IDX_OUT, v); chk("R4 R5 set under mask", v, {24'h0, model});
            wr(IDX_CLR, 32'h3C);
            model = model & ~(8'h3C & ~masks[i]);
            rd(IDX_OUT, v); chk("R4 R5 clear under mask", v, {24'h0, model});
            rd(IDX_SET, v); chk("R12 set word reads 0", v, 0);
            rd(IDX_CLR, v); chk("R12 clear word reads 0", v, 0);
        end
        wr(IDX_MASK, 0);

        // R6: input latency, direct and synchronized
        foreach (lats[i]) begin
            @(negedge clk); pad_in = lats[i] ^ 8'h33;
            @(negedge clk);
            rd(IDX_IN, v); chk("R6 direct input after 1 edge", v, {24'h0, lats[i] ^ 8'h33});
        end
        wr(IDX_SYNC, 32'hFF);
        wait_cyc(5);
        @(negedge clk); pad_in = 8'hC3;
        wait_cyc(3);
        rd(IDX_IN, v); chk("R6 synced input still old after 3 edges", v, {24'h0, 8'h33});
        wait_cyc(1);
        rd(IDX_IN, v); chk("R6 synced input new after 4 edges", v, {24'h0, 8'hC3});
        wr(IDX_SYNC, 0);

        // R7 R8 R9 R10 R11 R12: interrupt configuration sweep, both input paths
        for (int s = 0; s < 2; s++) begin
            logic [7:0] sy;
            sy = (s == 0) ? 8'h00 : 8'hFF;
            irq_sweep(8'h00, 8'hFF, 8'h00, 8'hFF, sy);  // rising edges
            irq_sweep(8'h00, 8'h00, 8'h00, 8'hFF, sy);  // falling edges
            irq_sweep(8'h00, 8'h0F, 8'hF0, 8'hFF, sy);  // any-edge override
            irq_sweep(8'hFF, 8'h55, 8'h00, 8'hFF, sy);  // levels
            irq_sweep(8'h0F, 8'h33, 8'h55, 8'hC3, sy);  // mixed, partial enable
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule